// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps the time of day and the calendar date as a chain of packed binary-coded-decimal counters. The chain runs from hundredths of a second up to the year, and it also holds a century flag. An external divider supplies a single-cycle `tick` enable once every hundredth of a second. Each accepted tick advances the hundredths. Any carry ripples through seconds, minutes, hours, date, day of week, month and year within that same clock cycle. The date wraps at the true length of the current month, and February gets its extra day in years divisible by four.

Software or a bus bridge sets the clock through a one-cycle write strobe, a field selector and a data byte. A write to any field also forces the hundredths back to 00, so the sub-second phase starts again from the moment of the write. A `stop` input freezes the whole chain. Every field is presented as a byte. A one-cycle `update` pulse marks the cycle in which freshly advanced values appear, so that neighbouring logic can copy a coherent snapshot.

Top module: `bcd_calendar`

## Requirements
- R1: Hundredths count 00..99 and seconds 00..59 in packed BCD (tens digit in bits 7:4, units digit in bits 3:0). Each accepted tick adds one hundredth. Hundredths wrapping from 99 to 00 adds one second.
- R2: Minutes count 00..59 and hours count 00..23 in BCD. All carries from hundredths up to hours take effect on the same tick.
- R3: The date counts from 01 to the length of the current month and then wraps to 01, advancing the month. Months 04, 06, 09 and 11 have 30 days. February has 29 days when the BCD year is divisible by 4 and 28 days otherwise. All other months have 31 days.
- R4: The day of week is a 3-bit value 1..7. It advances at the same midnight as the date and wraps from 7 to 1.
- R5: The month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00.
- R6: When the century-enable bit is 1, the century bit inverts when the year wraps from 99 to 00. When the enable bit is 0, the century bit keeps its value.
- R7: While `stop` is 1, ticks are ignored. Every field keeps its value and `update` stays 0.
- R8: When `wr_en` is 1, the field chosen by `wr_sel` takes `wr_data` on the next cycle. The encoding is: 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day of week (bits 2:0), 5 date, 6 month, 7 year. For hours, bit 7 is the century enable, bit 6 is the century bit and bits 5:0 are the hours, and `hour_o` reads back in the same layout. Every write clears the hundredths to 00, and a write to selector 0 stores 00 whatever the data.
- R9: A tick that arrives in the same cycle as a write is discarded. Only the write takes effect, and `update` stays 0 in the following cycle.
- R10: `update` is 1 for exactly the cycle after each accepted tick, when the advanced values are already on the outputs. It is 0 otherwise.
- R11: After a synchronous reset the clock reads 00:00:00.00, day of week 1, date 01, month 01, year 00, century enable 0, century 0, with `update` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle enable at one hundredth of a second |
| stop | input | 1 | Freezes the counters while high |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field selector for writes |
| wr_data | input | 8 | Write data byte |
| hund_o | output | 8 | Hundredths, BCD |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Century enable, century bit, hours in BCD |
| dow_o | output | 8 | Day of week 1..7 in bits 2:0 |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year, BCD |
| update | output | 1 | One-cycle pulse with freshly advanced fields |

## Verification
Some properties are checked by assertions on every cycle. These are: the frozen state under `stop`, hundredths being cleared after any write, `update` following an accepted tick and only an accepted tick, the century bit holding while its enable is 0, and digit ranges on seconds and hours. The month-length rules, leap years, the day-of-week wrap and the full carry from 23:59:59.99 on 31 December into a new year and century depend on long sequences of ticks and specific preloaded dates. Only the bench's directed scenarios reach those cases.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int BYTE_W = 8;
    localparam int SEL_W  = 3;
    localparam int DOW_W  = 3;
    localparam int TOD_N  = 4;

    typedef logic [BYTE_W-1:0] bcd_t;

    typedef enum logic [SEL_W-1:0] {
        FLD_HUND  = 3'd0,
        FLD_SEC   = 3'd1,
        FLD_MIN   = 3'd2,
        FLD_HOUR  = 3'd3,
        FLD_DOW   = 3'd4,
        FLD_DATE  = 3'd5,
        FLD_MONTH = 3'd6,
        FLD_YEAR  = 3'd7
    } field_e;

    localparam logic [DOW_W-1:0] DOW_FIRST = 3'd1;
    localparam logic [DOW_W-1:0] DOW_LAST  = 3'd7;

    typedef struct packed {
        logic             cen_en;
        logic             century;
        logic [DOW_W-1:0] dow;
    } cal_misc_t;

    function automatic bcd_t bcd_step(input bcd_t v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic bcd_leap(input bcd_t yr);
        logic [1:0] m4;
        m4 = {yr[4], 1'b0} + yr[1:0];
        return m4 == 2'd0;
    endfunction

    function automatic bcd_t month_days(input bcd_t mon, input bcd_t yr);
        case (mon)
            8'h02:                   return bcd_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                 return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_bcd_ctr.sv
module cal_bcd_ctr
    import cal_pkg::*;
#(
    parameter bcd_t LO  = 8'h00,
    parameter bcd_t RST = 8'h00
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic ld,
    input  bcd_t ld_val,
    input  bcd_t hi,
    output bcd_t q,
    output logic wrap
);

    assign wrap = inc && !ld && (q >= hi);

    always_ff @(posedge clk) begin
        if (rst)
            q <= RST;
        else if (ld)
            q <= ld_val;
        else if (inc)
            q <= (q >= hi) ? LO : bcd_step(q);
    end

endmodule

// File: rtl/cal_month_len.sv
module cal_month_len
    import cal_pkg::*;
(
    input  bcd_t month,
    input  bcd_t year,
    output bcd_t last_day
);

    assign last_day = month_days(month, year);

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       stop,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] hund_o,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] dow_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o,
    output logic       update
);

    localparam bcd_t TOD_HI [TOD_N] = '{8'h99, 8'h59, 8'h59, 8'h23};

    logic       adv;
    logic [TOD_N:0] carry;
    bcd_t       tod [TOD_N];
    bcd_t       date_q, month_q, year_q, last_day;
    logic       date_wrap, month_wrap, year_wrap;
    cal_misc_t  misc;

    assign adv      = tick && !stop && !wr_en;
    assign carry[0] = adv;

    for (genvar g = 0; g < TOD_N; g++) begin : g_tod
        logic ld_g;
        bcd_t val_g;
        if (g == 0) begin : g_clr
            assign ld_g  = wr_en;
            assign val_g = 8'h00;
        end else if (g == TOD_N - 1) begin : g_hr
            assign ld_g  = wr_en && (wr_sel == SEL_W'(g));
            assign val_g = {2'b00, wr_data[5:0]};
        end else begin : g_ms
            assign ld_g  = wr_en && (wr_sel == SEL_W'(g));
            assign val_g = wr_data;
        end
        cal_bcd_ctr #(.LO(8'h00), .RST(8'h00)) u_ctr (
            .clk(clk), .rst(rst), .inc(carry[g]), .ld(ld_g),
            .ld_val(val_g), .hi(TOD_HI[g]), .q(tod[g]), .wrap(carry[g+1])
        );
    end

    cal_month_len u_len (.month(month_q), .year(year_q), .last_day(last_day));

    cal_bcd_ctr #(.LO(8'h01), .RST(8'h01)) u_date (
        .clk(clk), .rst(rst), .inc(carry[TOD_N]),
        .ld(wr_en && wr_sel == FLD_DATE), .ld_val(wr_data),
        .hi(last_day), .q(date_q), .wrap(date_wrap)
    );

    cal_bcd_ctr #(.LO(8'h01), .RST(8'h01)) u_month (
        .clk(clk), .rst(rst), .inc(date_wrap),
        .ld(wr_en && wr_sel == FLD_MONTH), .ld_val(wr_data),
        .hi(8'h12), .q(month_q), .wrap(month_wrap)
    );

    cal_bcd_ctr #(.LO(8'h00), .RST(8'h00)) u_year (
        .clk(clk), .rst(rst), .inc(month_wrap),
        .ld(wr_en && wr_sel == FLD_YEAR), .ld_val(wr_data),
        .hi(8'h99), .q(year_q), .wrap(year_wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            misc   <= '{cen_en: 1'b0, century: 1'b0, dow: DOW_FIRST};
            update <= 1'b0;
        end else begin
            update <= adv;
            if (wr_en && wr_sel == FLD_HOUR) begin
                misc.cen_en  <= wr_data[7];
                misc.century <= wr_data[6];
            end else if (year_wrap && misc.cen_en) begin
                misc.century <= ~misc.century;
            end
            if (wr_en && wr_sel == FLD_DOW)
                misc.dow <= wr_data[DOW_W-1:0];
            else if (carry[TOD_N])
                misc.dow <= (misc.dow >= DOW_LAST) ? DOW_FIRST : misc.dow + 3'd1;
        end
    end

    assign hund_o  = tod[0];
    assign sec_o   = tod[1];
    assign min_o   = tod[2];
    assign hour_o  = {misc.cen_en, misc.century, tod[3][5:0]};
    assign dow_o   = {{(BYTE_W-DOW_W){1'b0}}, misc.dow};
    assign date_o  = date_q;
    assign month_o = month_q;
    assign year_o  = year_q;

endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       stop,
    input logic       wr_en,
    input logic [7:0] hund_o,
    input logic [7:0] sec_o,
    input logic [7:0] min_o,
    input logic [7:0] hour_o,
    input logic [7:0] dow_o,
    input logic [7:0] date_o,
    input logic [7:0] month_o,
    input logic [7:0] year_o,
    input logic       update
);

    p_sec_digits_r1: assert property (@(posedge clk) disable iff (rst)
        sec_o[3:0] <= 4'd9 && sec_o[7:4] <= 4'd5);

    p_hour_range_r2: assert property (@(posedge clk) disable iff (rst)
        hour_o[5:0] <= 6'h23);

    p_century_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!hour_o[7] && !wr_en) |=> hour_o[6] == $past(hour_o[6]));

    p_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (stop && !wr_en) |=> $stable({hund_o, sec_o, min_o, hour_o,
                                      dow_o, date_o, month_o, year_o}) && !update);

    p_write_clears_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> hund_o == 8'h00);

    p_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !update);

    p_tick_pulses_r10: assert property (@(posedge clk) disable iff (rst)
        (tick && !stop && !wr_en) |=> update && hund_o != $past(hund_o));

    p_no_spurious_r10: assert property (@(posedge clk) disable iff (rst)
        !tick |=> !update);

endmodule

bind bcd_calendar bcd_calendar_chk u_chk (
    .clk(clk), .rst(rst), .tick(tick), .stop(stop), .wr_en(wr_en),
    .hund_o(hund_o), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .dow_o(dow_o), .date_o(date_o), .month_o(month_o), .year_o(year_o),
    .update(update)
);

// File: tb/bcd_calendar_test.sv
`timescale 1ns/1ps
module bcd_calendar_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       stop = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] hund_o, sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
    logic       update;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bcd_calendar uut (
        .clk(clk), .rst(rst), .tick(tick), .stop(stop), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .hund_o(hund_o), .sec_o(sec_o),
        .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o), .date_o(date_o),
        .month_o(month_o), .year_o(year_o), .update(update)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    // preload 23:59:59 (hundredths cleared by the writes), then run to midnight
    task automatic to_midnight(input logic [7:0] hour_byte);
        wr(3'd3, hour_byte);
        wr(3'd2, 8'h59);
        wr(3'd1, 8'h59);
        ticks(100);
    endtask

    task automatic t_reset();
        chk("R11", "hund", hund_o, 8'h00);
        chk("R11", "sec", sec_o, 8'h00);
        chk("R11", "min", min_o, 8'h00);
        chk("R11", "hour", hour_o, 8'h00);
        chk("R11", "dow", dow_o, 8'h01);
        chk("R11", "date", date_o, 8'h01);
        chk("R11", "month", month_o, 8'h01);
        chk("R11", "year", year_o, 8'h00);
        chk("R11", "update", {7'd0, update}, 8'h00);
    endtask

    task automatic t_basic_and_pulse();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        chk("R10", "update after tick", {7'd0, update}, 8'h01);
        chk("R1", "hund after 1 tick", hund_o, 8'h01);
        @(negedge clk);
        chk("R10", "update one cycle only", {7'd0, update}, 8'h00);
        ticks(9);
        chk("R1", "hund BCD units carry", hund_o, 8'h10);
        ticks(90);
        chk("R1", "hund wraps", hund_o, 8'h00);
        chk("R1", "seconds carry", sec_o, 8'h01);
    endtask

    task automatic t_new_year(input logic cen_en, input logic cen);
        wr(3'd7, 8'h99);
        wr(3'd6, 8'h12);
        wr(3'd5, 8'h31);
        wr(3'd4, 8'h07);
        to_midnight({cen_en, cen, 6'h23});
        chk("R2", "hour/min/sec rollover", {hour_o[5:0], 2'b00} | sec_o | min_o, 8'h00);
        chk("R4", "dow 7 wraps to 1", dow_o, 8'h01);
        chk("R3", "date 31 wraps", date_o, 8'h01);
        chk("R5", "month 12 wraps", month_o, 8'h01);
        chk("R5", "year 99 wraps", year_o, 8'h00);
        chk("R6", "century bit", {7'd0, hour_o[6]}, {7'd0, cen_en ? ~cen : cen});
        chk("R6", "century enable kept", {7'd0, hour_o[7]}, {7'd0, cen_en});
    endtask

    task automatic t_month_end(input logic [7:0] yr, input logic [7:0] mon,
                               input logic [7:0] day, input logic [7:0] exp_date,
                               input logic [7:0] exp_mon, input string what);
        wr(3'd7, yr);
        wr(3'd6, mon);
        wr(3'd5, day);
        wr(3'd4, 8'h03);
        to_midnight(8'h23);
        chk("R3", {what, " date"}, date_o, exp_date);
        chk("R3", {what, " month"}, month_o, exp_mon);
        chk("R4", {what, " dow advances"}, dow_o, 8'h04);
    endtask

    task automatic t_stop();
        logic [7:0] h, s;
        ticks(7);
        h = hund_o; s = sec_o;
        stop = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            chk("R7", "update while stopped", {7'd0, update}, 8'h00);
        end
        chk("R7", "hund frozen", hund_o, h);
        chk("R7", "sec frozen", sec_o, s);
        stop = 1'b0;
        ticks(1);
        chk("R7", "resumes after stop", hund_o, bcd_inc(h));
    endtask

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
    endfunction

    task automatic t_writes();
        ticks(5);
        wr(3'd2, 8'h42);
        chk("R8", "minutes written", min_o, 8'h42);
        chk("R8", "write clears hund", hund_o, 8'h00);
        ticks(3);
        wr(3'd0, 8'h45);
        chk("R8", "hund accepts only 00", hund_o, 8'h00);
        chk("R8", "other field untouched", min_o, 8'h42);
    endtask

    task automatic t_tick_with_write();
        ticks(4);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd1; wr_data = 8'h17; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        chk("R9", "update suppressed", {7'd0, update}, 8'h00);
        chk("R9", "hund not advanced", hund_o, 8'h00);
        chk("R9", "write applied", sec_o, 8'h17);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic_and_pulse();
        t_new_year(1'b1, 1'b0);
        t_new_year(1'b0, 1'b1);
        t_month_end(8'h12, 8'h02, 8'h28, 8'h29, 8'h02, "Feb leap 12");
        t_month_end(8'h24, 8'h02, 8'h29, 8'h01, 8'h03, "Feb 29 end");
        t_month_end(8'h10, 8'h02, 8'h28, 8'h01, 8'h03, "Feb non-leap 10");
        t_month_end(8'h23, 8'h04, 8'h30, 8'h01, 8'h05, "Apr 30");
        t_month_end(8'h23, 8'h11, 8'h30, 8'h01, 8'h12, "Nov 30");
        t_month_end(8'h23, 8'h01, 8'h30, 8'h31, 8'h01, "Jan 30");
        t_stop();
        t_writes();
        t_tick_with_write();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule